// File: doc/BRIEF.md
# Master/Slave Framed Synchronous Serial Port

This block is a full-duplex synchronous serial port. It can drive the serial clock itself (master) or follow a clock from outside (slave). A host loads 16-bit words into a transmit FIFO and takes 16-bit words out of a receive FIFO. Each FIFO holds sixteen words. On the line, every word travels as two bytes. Each byte is announced by a frame pulse one serial clock period wide, placed in the period just before its first bit.

In master mode the serial clock comes from the system clock through a programmable divider. The port drives the clock and both frame pins. It runs a word whenever the transmit side has data or the receive side is enabled. In slave mode the clock, both frame pins and receive data are inputs. They are synchronised into the system clock domain, and their edges are detected there. Two level interrupts report the FIFO fill levels. Sticky flags record transmit underrun and receive overrun.

The host interface uses valid/ready handshakes:
- A write is accepted only in a cycle where both `wr_valid` and `wr_ready` are high. `wr_ready` is low while the transmit FIFO is full, and a write offered then is dropped.
- `rd_valid` is high while the receive FIFO holds a word. A pop happens in a cycle where both `rd_valid` and `rd_ready` are high.

Top module: `fsync_serial_port`

## Requirements
- R1: The transmit FIFO holds 16 words of 16 bits. `wr_ready` is low exactly when it is full, and a write offered while full is discarded, leaving the queued data unchanged.
- R2: `irq_rx` is high while the receive FIFO holds 8 or more words. `irq_tx` is high while the transmit FIFO holds 8 or fewer words.
- R3: A word is sent as its low byte (bits 7:0) followed by its high byte (bits 15:8), each byte most significant bit first. A received byte pair is assembled into one word in the same order.
- R4: Each byte is preceded by a frame pulse that lasts exactly one serial clock period, in the period just before the first data bit. Data and frame change on the rising serial clock edge and are sampled on the falling edge.
- R5: When `master_en` is 1, `sclk_oe`, `txfs_oe` and `rxfs_oe` are 1. When `master_en` is 0, all three are 0. `txd_o` is driven in both modes.
- R6: In master mode, each serial clock phase lasts `clk_div`+1 system clock cycles. Words run back to back while the transmit FIFO has data or the receive side is enabled.
- R7: With `tx_en` and `rx_en` both 0, `sclk_o` and the frame outputs stay low.
- R8: If a word starts on the transmit side while the transmit FIFO is empty, the port sends zero bytes and sets `tx_underrun`. If a word completes while the receive FIFO is full, the word is dropped and `rx_overrun` is set. Both flags hold until `err_clr` is pulsed.
- R9: In slave mode, transmit bytes follow frame pulses on `txfs_i` and receive bytes follow frame pulses on `rxfs_i`, both timed by `sclk_i`. Each phase of `sclk_i` must last at least 4 system clock cycles.
- R10: With the receive FIFO empty, `rd_valid` is 0 and `rd_data` is 0, and asserting `rd_ready` changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| master_en | input | 1 | 1 selects master mode |
| tx_en | input | 1 | Transmit side enable |
| rx_en | input | 1 | Receive side enable |
| clk_div | input | DIV_W | Master clock phase length minus one, in system cycles |
| err_clr | input | 1 | Clears the sticky error flags |
| wr_valid | input | 1 | Host offers a transmit word |
| wr_ready | output | 1 | Transmit FIFO has room |
| wr_data | input | 16 | Transmit word |
| rd_valid | output | 1 | Receive FIFO holds a word |
| rd_ready | input | 1 | Host takes the receive word |
| rd_data | output | 16 | Head of the receive FIFO, 0 when empty |
| irq_tx | output | 1 | Transmit FIFO at most half full |
| irq_rx | output | 1 | Receive FIFO at least half full |
| tx_underrun | output | 1 | Sticky transmit underrun flag |
| rx_overrun | output | 1 | Sticky receive overrun flag |
| sclk_i | input | 1 | Serial clock in (slave) |
| sclk_o | output | 1 | Serial clock out (master) |
| sclk_oe | output | 1 | Serial clock output enable |
| txfs_i | input | 1 | Transmit frame in (slave) |
| txfs_o | output | 1 | Transmit frame out (master) |
| txfs_oe | output | 1 | Transmit frame output enable |
| rxfs_i | input | 1 | Receive frame in (slave) |
| rxfs_o | output | 1 | Receive frame out (master) |
| rxfs_oe | output | 1 | Receive frame output enable |
| txd_o | output | 1 | Serial transmit data |
| rxd_i | input | 1 | Serial receive data |

## Verification
In master mode the port is tried in two ways, each with `txd_o` looped back to `rxd_i`:
- Two distinct words at a divided clock. This separates byte order and bit order, because a swapped byte or reversed bit changes both the wire byte and the word read back. It also measures the clock phase length.
- A full FIFO drained at the fastest clock. The sixteen ascending words followed by zeros show that the seventeenth write was discarded and that underrun sends zeros.

In slave mode a bench-driven clock and frame stream checks transmit framing. A run of seventeen words on the receive side checks the interrupt threshold between eight and seven words, overrun on the seventeenth word, and that the first sixteen words are kept in order.

// File: rtl/fssp_pkg.sv
package fssp_pkg;
  localparam int BYTE_W = 8;
  localparam int BYTES_PER_WORD = 2;
  localparam int WORD_W = BYTE_W * BYTES_PER_WORD;
  localparam int BIT_CNT_W = $clog2(BYTE_W + 1);
  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/fssp_fifo.sv
module fssp_fifo #(
  parameter int W = 16,
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         full,
  output logic         empty,
  output logic [AW:0]  level
);
  logic [W-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic do_push, do_pop;

  assign full    = (level == DEPTH[AW:0]);
  assign empty   = (level == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign rdata   = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0;
      rp <= '0;
      level <= '0;
    end else begin
      if (do_push) wp <= wp + 1'b1;
      if (do_pop)  rp <= rp + 1'b1;
      case ({do_push, do_pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/fssp_clkgen.sv
module fssp_clkgen #(
  parameter int DIV_W = 8,
  parameter int SYNC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             master_en,
  input  logic             run,
  input  logic             want_word,
  input  logic [DIV_W-1:0] div,
  input  logic             sclk_i,
  input  logic             txfs_i,
  input  logic             rxfs_i,
  input  logic             rxd_i,
  output logic             sclk_o,
  output logic             fs_o,
  output logic             rise,
  output logic             fall,
  output logic             tx_fs,
  output logic             rx_fs,
  output logic             rxd_s
);
  import fssp_pkg::*;

  // slave side: synchronise clock, frames and data with equal latency
  logic [3:0] raw, sy;
  assign raw = {rxd_i, rxfs_i, txfs_i, sclk_i};
  for (genvar g = 0; g < 4; g++) begin : g_sync
    logic [SYNC-1:0] st;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st <= '0;
      else        st <= {st[SYNC-2:0], raw[g]};
    end
    assign sy[g] = st[SYNC-1];
  end

  logic sclk_prev;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_prev <= 1'b0;
    else        sclk_prev <= sy[0];
  end

  // master side: divider, frame generator
  logic [DIV_W-1:0] cnt;
  logic [BIT_CNT_W-1:0] per;
  logic sclk_q, fs_q, byte_odd, running, tick;

  assign running = master_en && run;
  assign tick    = running && (cnt == div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; sclk_q <= 1'b0; fs_q <= 1'b0; per <= '0; byte_odd <= 1'b0;
    end else if (!running) begin
      cnt <= '0; sclk_q <= 1'b0; fs_q <= 1'b0; per <= '0; byte_odd <= 1'b0;
    end else if (tick) begin
      cnt <= '0;
      sclk_q <= ~sclk_q;
      if (!sclk_q) begin
        if (per == '0) begin
          if (byte_odd || want_word) begin
            fs_q <= 1'b1;
            per <= BIT_CNT_W'(1);
            byte_odd <= ~byte_odd;
          end else begin
            fs_q <= 1'b0;
          end
        end else begin
          fs_q <= 1'b0;
          per <= (per == BIT_CNT_W'(BYTE_W)) ? '0 : per + 1'b1;
        end
      end
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign sclk_o = sclk_q;
  assign fs_o   = fs_q;
  assign rise   = master_en ? (tick && !sclk_q) : (sy[0] && !sclk_prev);
  assign fall   = master_en ? (tick && sclk_q)  : (!sy[0] && sclk_prev);
  assign tx_fs  = master_en ? fs_q  : sy[1];
  assign rx_fs  = master_en ? fs_q  : sy[2];
  assign rxd_s  = master_en ? rxd_i : sy[3];
endmodule

// File: rtl/fssp_tx.sv
module fssp_tx
  import fssp_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  en,
  input  logic  rise,
  input  logic  fall,
  input  logic  fs,
  input  logic  fifo_empty,
  input  word_t fifo_data,
  output logic  pop,
  output logic  underrun,
  output logic  txd
);
  byte_t shreg, hi;
  logic [BIT_CNT_W-1:0] left;
  logic odd, txd_q, load;

  assign load     = en && fall && fs && (left == '0);
  assign pop      = load && !odd && !fifo_empty;
  assign underrun = load && !odd && fifo_empty;
  assign txd      = txd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0; hi <= '0; left <= '0; odd <= 1'b0; txd_q <= 1'b0;
    end else if (!en) begin
      left <= '0; odd <= 1'b0; txd_q <= 1'b0;
    end else if (load) begin
      left <= BIT_CNT_W'(BYTE_W);
      if (!odd) begin
        shreg <= fifo_empty ? '0 : fifo_data[BYTE_W-1:0];
        hi    <= fifo_empty ? '0 : fifo_data[WORD_W-1:BYTE_W];
        odd   <= 1'b1;
      end else begin
        shreg <= hi;
        odd   <= 1'b0;
      end
    end else if (rise) begin
      if (left != '0) begin
        txd_q <= shreg[BYTE_W-1];
        shreg <= {shreg[BYTE_W-2:0], 1'b0};
        left  <= left - 1'b1;
      end else begin
        txd_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/fssp_rx.sv
module fssp_rx
  import fssp_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  en,
  input  logic  fall,
  input  logic  fs,
  input  logic  rxd,
  output logic  push,
  output word_t word
);
  byte_t sh, lo, nxt;
  logic [BIT_CNT_W-1:0] left;
  logic odd;

  assign nxt  = {sh[BYTE_W-2:0], rxd};
  assign push = en && fall && (left == BIT_CNT_W'(1)) && odd;
  assign word = {nxt, lo};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh <= '0; lo <= '0; left <= '0; odd <= 1'b0;
    end else if (!en) begin
      left <= '0; odd <= 1'b0;
    end else if (fall) begin
      if (left != '0) begin
        sh <= nxt;
        left <= left - 1'b1;
        if (left == BIT_CNT_W'(1)) begin
          if (!odd) lo <= nxt;
          odd <= ~odd;
        end
      end else if (fs) begin
        left <= BIT_CNT_W'(BYTE_W);
      end
    end
  end
endmodule

// File: rtl/fsync_serial_port.sv
module fsync_serial_port #(
  parameter int DEPTH = 16,
  parameter int DIV_W = 8,
  parameter int SYNC = 2,
  localparam int AW = $clog2(DEPTH),
  localparam int HALF = DEPTH / 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             master_en,
  input  logic             tx_en,
  input  logic             rx_en,
  input  logic [DIV_W-1:0] clk_div,
  input  logic             err_clr,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [15:0]      wr_data,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic [15:0]      rd_data,
  output logic             irq_tx,
  output logic             irq_rx,
  output logic             tx_underrun,
  output logic             rx_overrun,
  input  logic             sclk_i,
  output logic             sclk_o,
  output logic             sclk_oe,
  input  logic             txfs_i,
  output logic             txfs_o,
  output logic             txfs_oe,
  input  logic             rxfs_i,
  output logic             rxfs_o,
  output logic             rxfs_oe,
  output logic             txd_o,
  input  logic             rxd_i
);
  import fssp_pkg::*;

  word_t tx_head, rx_head, rx_word;
  logic tx_full, tx_empty, rx_full, rx_empty;
  logic [AW:0] tx_level, rx_level;
  logic tx_pop, rx_push, ur_set;
  logic rise, fall, tx_fs, rx_fs, rxd_s, fs_q;

  fssp_fifo #(.W(WORD_W), .DEPTH(DEPTH)) u_txq (
    .clk, .rst_n, .push(wr_valid), .wdata(wr_data), .pop(tx_pop),
    .rdata(tx_head), .full(tx_full), .empty(tx_empty), .level(tx_level));

  fssp_fifo #(.W(WORD_W), .DEPTH(DEPTH)) u_rxq (
    .clk, .rst_n, .push(rx_push), .wdata(rx_word), .pop(rd_ready),
    .rdata(rx_head), .full(rx_full), .empty(rx_empty), .level(rx_level));

  fssp_clkgen #(.DIV_W(DIV_W), .SYNC(SYNC)) u_clk (
    .clk, .rst_n, .master_en, .run(tx_en || rx_en),
    .want_word((tx_en && !tx_empty) || rx_en), .div(clk_div),
    .sclk_i, .txfs_i, .rxfs_i, .rxd_i,
    .sclk_o, .fs_o(fs_q), .rise, .fall, .tx_fs, .rx_fs, .rxd_s);

  fssp_tx u_tx (
    .clk, .rst_n, .en(tx_en), .rise, .fall, .fs(tx_fs),
    .fifo_empty(tx_empty), .fifo_data(tx_head), .pop(tx_pop),
    .underrun(ur_set), .txd(txd_o));

  fssp_rx u_rx (
    .clk, .rst_n, .en(rx_en), .fall, .fs(rx_fs), .rxd(rxd_s),
    .push(rx_push), .word(rx_word));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_underrun <= 1'b0;
      rx_overrun  <= 1'b0;
    end else begin
      tx_underrun <= ur_set || (tx_underrun && !err_clr);
      rx_overrun  <= (rx_push && rx_full) || (rx_overrun && !err_clr);
    end
  end

  assign wr_ready = !tx_full;
  assign rd_valid = !rx_empty;
  assign rd_data  = rx_empty ? '0 : rx_head;
  assign irq_rx   = (rx_level >= (AW+1)'(HALF));
  assign irq_tx   = (tx_level <= (AW+1)'(HALF));
  assign txfs_o   = fs_q;
  assign rxfs_o   = fs_q;
  assign sclk_oe  = master_en;
  assign txfs_oe  = master_en;
  assign rxfs_oe  = master_en;
endmodule

// File: rtl/fssp_checker.sv
module fssp_checker #(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input logic        clk,
  input logic        rst_n,
  input logic        master_en,
  input logic        tx_en,
  input logic        rx_en,
  input logic        err_clr,
  input logic        sclk_o,
  input logic        txfs_o,
  input logic        tx_underrun,
  input logic        rx_overrun,
  input logic        irq_rx,
  input logic        rx_push,
  input logic [AW:0] tx_level
);
  AST_FS_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (master_en && $past(master_en) && (tx_en || rx_en) && $past(tx_en || rx_en) && !$stable(txfs_o))
      |-> $rose(sclk_o)); // R4

  AST_IDLE_NO_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_en && !rx_en && $past(!tx_en && !rx_en)) |-> (!sclk_o && !txfs_o)); // R7

  AST_UNDERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(tx_underrun) && !$past(err_clr)) |-> tx_underrun); // R8

  AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rx_overrun) && !$past(err_clr)) |-> rx_overrun); // R8

  AST_IRQ_RX_AFTER_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_rx) |-> $past(rx_push)); // R2

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    tx_level <= (AW+1)'(DEPTH)); // R1
endmodule

bind fsync_serial_port fssp_checker #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .master_en(master_en), .tx_en(tx_en), .rx_en(rx_en),
  .err_clr(err_clr), .sclk_o(sclk_o), .txfs_o(txfs_o), .tx_underrun(tx_underrun),
  .rx_overrun(rx_overrun), .irq_rx(irq_rx), .rx_push(rx_push), .tx_level(tx_level));

// File: tb/fsync_serial_port_tb.sv
module fsync_serial_port_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic master_en = 0, tx_en = 0, rx_en = 0, err_clr = 0;
  logic [7:0] clk_div = 8'd0;
  logic wr_valid = 0, rd_ready = 0;
  logic [15:0] wr_data = '0;
  logic wr_ready, rd_valid, irq_tx, irq_rx, tx_underrun, rx_overrun;
  logic [15:0] rd_data;
  logic sclk_i = 0, txfs_i = 0, rxfs_i = 0, rxd_drv = 0, loop = 0;
  logic sclk_o, sclk_oe, txfs_o, txfs_oe, rxfs_o, rxfs_oe, txd_o, rxd_pin;
  int checks = 0, errors = 0;

  assign rxd_pin = loop ? txd_o : rxd_drv;
  always #5 clk = ~clk;

  fsync_serial_port u_dut (
    .clk, .rst_n, .master_en, .tx_en, .rx_en, .clk_div, .err_clr,
    .wr_valid, .wr_ready, .wr_data, .rd_valid, .rd_ready, .rd_data,
    .irq_tx, .irq_rx, .tx_underrun, .rx_overrun,
    .sclk_i, .sclk_o, .sclk_oe, .txfs_i, .txfs_o, .txfs_oe,
    .rxfs_i, .rxfs_o, .rxfs_oe, .txd_o, .rxd_i(rxd_pin));

  // wire monitor for master mode: decodes bytes at falling serial clock
  logic [7:0] mon_byte [0:63];
  int mon_n = 0;
  logic mon_prev = 0, mon_on = 0;
  int mon_bits = 0;
  logic [7:0] mon_sh = 0;
  always @(negedge clk) begin
    if (mon_prev && !sclk_o) begin
      if (mon_on) begin
        mon_sh = {mon_sh[6:0], txd_o};
        mon_bits++;
        if (mon_bits == 8) begin
          if (mon_n < 64) mon_byte[mon_n] = mon_sh;
          mon_n++;
          mon_on = 0;
        end
      end else if (txfs_o) begin
        mon_on = 1;
        mon_bits = 0;
      end
    end
    mon_prev = sclk_o;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic push_word(input logic [15:0] d);
    @(negedge clk);
    wr_valid = 1; wr_data = d;
    @(negedge clk);
    wr_valid = 0;
  endtask

  task automatic pop_word(output logic [15:0] d);
    int t = 0;
    @(negedge clk);
    while (!rd_valid && t < 5000) begin @(negedge clk); t++; end
    d = rd_data;
    rd_ready = 1;
    @(negedge clk);
    rd_ready = 0;
  endtask

  task automatic flush();
    logic [15:0] d;
    @(negedge clk);
    tx_en = 0; rx_en = 0; loop = 0;
    repeat (20) @(negedge clk);
    while (rd_valid) pop_word(d);
    err_clr = 1; @(negedge clk); err_clr = 0;
  endtask

  task automatic s_period(input logic fs, input logic d, output logic tb);
    sclk_i = 1; txfs_i = fs; rxfs_i = fs; rxd_drv = d;
    repeat (6) @(negedge clk);
    tb = txd_o;
    sclk_i = 0;
    repeat (6) @(negedge clk);
  endtask

  task automatic s_byte(input logic [7:0] rb, output logic [7:0] tb);
    logic b;
    s_period(1'b1, 1'b0, b);
    for (int i = 7; i >= 0; i--) begin
      s_period(1'b0, rb[i], b);
      tb[i] = b;
    end
  endtask

  task automatic t_reset();
    chk("R1 reset wr_ready", wr_ready, 1);
    chk("R10 reset rd_valid", rd_valid, 0);
    chk("R10 reset rd_data", rd_data, 0);
    chk("R2 reset irq_tx", irq_tx, 1);
    chk("R2 reset irq_rx", irq_rx, 0);
    chk("R8 reset flags", {tx_underrun, rx_overrun}, 0);
  endtask

  task automatic t_pins();
    @(negedge clk); master_en = 0; @(negedge clk);
    chk("R5 slave oe", {sclk_oe, txfs_oe, rxfs_oe}, 3'b000);
    master_en = 1; @(negedge clk);
    chk("R5 master oe", {sclk_oe, txfs_oe, rxfs_oe}, 3'b111);
  endtask

  task automatic t_master_loop();
    int base, n;
    logic [15:0] d;
    master_en = 1; clk_div = 8'd2; loop = 1;
    push_word(16'h1234);
    push_word(16'hBEEF);
    base = mon_n;
    @(negedge clk); tx_en = 1; rx_en = 1;
    while (sclk_o !== 1'b0) @(negedge clk);
    while (sclk_o !== 1'b1) @(negedge clk);
    n = 0;
    while (sclk_o === 1'b1) begin @(negedge clk); n++; end
    chk("R6 phase length div 2", n, 3);
    pop_word(d); chk("R3 loop word 0", d, 16'h1234);
    pop_word(d); chk("R3 loop word 1", d, 16'hBEEF);
    pop_word(d); chk("R8 underrun zero word", d, 16'h0000);
    chk("R4 wire byte count", (mon_n - base >= 5), 1);
    chk("R3 wire byte 0 low first", mon_byte[base], 8'h34);
    chk("R3 wire byte 1", mon_byte[base+1], 8'h12);
    chk("R3 wire byte 2", mon_byte[base+2], 8'hEF);
    chk("R3 wire byte 3", mon_byte[base+3], 8'hBE);
    chk("R8 underrun flag", tx_underrun, 1);
    flush();
    chk("R8 err_clr clears underrun", tx_underrun, 0);
  endtask

  task automatic t_fill();
    logic [15:0] d;
    int hi_seen;
    master_en = 1; clk_div = 8'd0;
    for (int i = 0; i < 17; i++) begin
      push_word(16'h5A00 + 16'(i));
      if (i == 7) chk("R2 irq_tx at 8", irq_tx, 1);
      if (i == 8) chk("R2 irq_tx at 9", irq_tx, 0);
      if (i == 15) chk("R1 wr_ready full", wr_ready, 0);
    end
    chk("R1 wr_ready still full", wr_ready, 0);
    hi_seen = 0;
    repeat (40) begin @(negedge clk); if (sclk_o || txfs_o) hi_seen++; end
    chk("R7 idle clock", hi_seen, 0);
    rd_ready = 1; @(negedge clk); rd_ready = 0;
    chk("R10 empty rd_valid", rd_valid, 0);
    chk("R10 empty rd_data", rd_data, 0);
    loop = 1; tx_en = 1; rx_en = 1;
    for (int i = 0; i < 16; i++) begin
      pop_word(d);
      chk("R1 drained word", d, 16'h5A00 + 16'(i));
    end
    pop_word(d); chk("R1 discarded 17th", d, 16'h0000);
    pop_word(d); chk("R8 zero after empty", d, 16'h0000);
    flush();
  endtask

  task automatic t_slave_tx();
    logic [7:0] b;
    master_en = 0;
    push_word(16'hC3A5);
    @(negedge clk); tx_en = 1;
    s_byte(8'h00, b); chk("R9 slave tx low byte", b, 8'hA5);
    s_byte(8'h00, b); chk("R9 slave tx high byte", b, 8'hC3);
    chk("R8 no underrun yet", tx_underrun, 0);
    s_byte(8'h00, b); chk("R8 slave underrun byte", b, 8'h00);
    chk("R8 slave underrun flag", tx_underrun, 1);
    flush();
  endtask

  task automatic t_slave_rx();
    logic [7:0] b;
    logic [15:0] d;
    master_en = 0;
    @(negedge clk); rx_en = 1;
    for (int w = 0; w < 17; w++) begin
      s_byte(8'h30 + 8'(w), b);
      s_byte(8'hC0 + 8'(w), b);
      repeat (6) @(negedge clk);
      if (w == 6) chk("R2 irq_rx at 7", irq_rx, 0);
      if (w == 7) chk("R2 irq_rx at 8", irq_rx, 1);
      if (w == 15) chk("R8 no overrun at 16", rx_overrun, 0);
    end
    chk("R8 overrun at 17", rx_overrun, 1);
    for (int i = 0; i < 16; i++) begin
      pop_word(d);
      chk("R9 slave rx word", d, {8'hC0 + 8'(i), 8'h30 + 8'(i)});
    end
    @(negedge clk);
    chk("R8 17th dropped", rd_valid, 0);
    flush();
    chk("R8 err_clr clears overrun", rx_overrun, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_pins();
    t_master_loop();
    t_fill();
    t_slave_tx();
    t_slave_rx();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule